// File: doc/BRIEF.md
# Linear Fractional Resampler Stage

This stage refines a trigger instant below the spacing of the samples it is given. Each incoming bracket carries two adjacent samples of a trigger channel that straddle a crossing, the two samples of a separate data channel taken at the same instants, a position index and a sequence tag. The stage draws a straight line between the two trigger samples, evaluates it at sixteen evenly spaced fractional steps and keeps the step whose value lies closest to zero. The data channel is then evaluated on its own straight line at that same step, so the data value reported belongs to the refined trigger instant rather than to either original sample.

The refined position is the incoming position index with four fractional bits appended. When the incoming index already carries three bits of eight-fold fine resolution below the raw sample index, the output position has a seven-bit fraction, that is 128 steps per raw sample (roughly 2.6 ps at a 3 GS/s raw rate). Brackets enter and results leave through valid/ready handshakes; one bracket can be accepted per clock, results come out in acceptance order with their tags, and a downstream consumer stitches them into a waveform by tag.

Top module: `lfr_resampler`

## Requirements
- R1: While and right after reset, `out_valid` is low and `in_ready` is high.
- R2: With the trigger samples taken as two's complement values a (`in_trig_lo`) and b (`in_trig_hi`), candidate k (k = 0 to SUB-1, SUB = 16) has the value a + floor(((b - a) * k + SUB/2) / SUB), i.e. the line rounded to nearest with halves rounded up.
- R3: The chosen step is the k whose candidate value has the smallest magnitude; when several candidates share that magnitude, the smallest such k is chosen.
- R4: `out_data` is the two's complement value c + floor(((e - c) * k + SUB/2) / SUB) at the chosen k, with c = `in_data_lo` and e = `in_data_hi`; it never lies outside the range spanned by c and e.
- R5: `out_pos` equals `in_pos` in its upper bits with the chosen k (4 bits for SUB = 16) in its least significant bits.
- R6: `out_tag` equals `in_tag` of the same bracket, and results leave in the order the brackets were accepted, none lost or duplicated.
- R7: While `out_ready` is held high, `in_ready` stays high, so a bracket can be accepted on every clock.
- R8: A bracket accepted on a rising edge has its result on the outputs with `out_valid` high after the fourth rising edge, counting the accepting edge as the first (fixed latency of four clocks).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pos`, `out_data` and `out_tag` hold their values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A bracket is offered |
| in_ready | output | 1 | The stage takes the offered bracket on this edge |
| in_trig_lo | input | TRIG_W | Earlier trigger sample, two's complement |
| in_trig_hi | input | TRIG_W | Later trigger sample, two's complement |
| in_data_lo | input | DATA_W | Data-channel sample at the earlier instant |
| in_data_hi | input | DATA_W | Data-channel sample at the later instant |
| in_pos | input | POS_W | Position index of the earlier sample |
| in_tag | input | TAG_W | Sequence tag carried to the output |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the offered result on this edge |
| out_pos | output | POS_W+log2(SUB) | Refined position: index with the chosen step appended |
| out_data | output | DATA_W | Data-channel value at the refined position |
| out_tag | output | TAG_W | Tag of the bracket this result belongs to |

## Verification
The bench builds the stage with a 6-bit trigger channel, an 8-bit data channel, a 6-bit position, a 12-bit tag and sixteen steps, using the comparison-tree search. The narrow trigger width lets every one of the 4096 ordered trigger pairs pass through, which covers full-scale pairs, pairs whose nearest-zero candidates tie, flat pairs and pairs with no crossing at all; the 8-bit data channel is driven with full-swing pairs in both directions so the widest difference and its rounding are reached. Random backpressure with idle gaps on the input exercises the stall and hold behaviour, and a separate back-to-back burst with the output always ready checks the one-per-clock rate and the four-clock latency.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

   localparam int LFR_MIN_SUB = 2;

   function automatic bit lfr_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lfr_lerp.sv
// Straight-line evaluation between two signed endpoints at step k of 2**KW,
// rounded to nearest (halves upward) by an arithmetic shift of the scaled sum.
module lfr_lerp #(
   parameter int W  = 12,
   parameter int KW = 4
) (
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic [KW-1:0] k_i,
   output logic [W-1:0]  y_o
);
   localparam int XW     = W + KW + 2;
   localparam int HALF_I = 1 << (KW - 1);

   logic signed [XW-1:0] a_x;
   logic signed [XW-1:0] d_x;
   logic signed [XW-1:0] k_x;
   logic signed [XW-1:0] h_x;

   assign a_x = XW'($signed(a_i));
   assign d_x = XW'($signed(b_i)) - XW'($signed(a_i));
   assign k_x = $signed(XW'(k_i));
   assign h_x = $signed(XW'(HALF_I));

   // (a*2^KW + d*k + half) >>> KW  ==  a + floor((d*k + half) / 2^KW)
   assign y_o = W'(((a_x <<< KW) + (d_x * k_x) + h_x) >>> KW);
endmodule

// File: rtl/lfr_argmin.sv
// Finds the index of the smallest distance; ties resolve to the lower index.
module lfr_argmin #(
   parameter int SUB         = 16,
   parameter int DIST_W      = 12,
   parameter bit TREE_SEARCH = 1'b1,
   localparam int KW         = $clog2(SUB)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         check_en,
   input  logic [SUB-1:0][DIST_W-1:0]   dist_i,
   output logic [KW-1:0]                sel_o
);
   generate
      if (TREE_SEARCH) begin : g_tree
         // heap layout: node n has children 2n and 2n+1, leaves SUB..2*SUB-1
         logic [DIST_W-1:0] hd [1:2*SUB-1];
         logic [KW-1:0]     hk [1:2*SUB-1];

         for (genvar lf = 0; lf < SUB; lf++) begin : g_leaf
            assign hd[SUB+lf] = dist_i[lf];
            assign hk[SUB+lf] = KW'(lf);
         end

         for (genvar nd = 1; nd < SUB; nd++) begin : g_node
            logic take_right;
            // left subtree holds the lower indices: keep it unless right is strictly closer
            assign take_right = hd[2*nd+1] < hd[2*nd];
            assign hd[nd] = take_right ? hd[2*nd+1] : hd[2*nd];
            assign hk[nd] = take_right ? hk[2*nd+1] : hk[2*nd];
         end

         assign sel_o = hk[1];
      end else begin : g_linear
         always_comb begin
            logic [DIST_W-1:0] best_d;
            best_d = dist_i[0];
            sel_o  = '0;
            for (int j = 1; j < SUB; j++) begin
               if (dist_i[j] < best_d) begin
                  best_d = dist_i[j];
                  sel_o  = KW'(j);
               end
            end
         end
      end
   endgenerate

   // Selection checks against every candidate
   generate
      for (genvar c = 0; c < SUB; c++) begin : g_chk
         // R3: no candidate is closer to zero than the chosen one
         a_r3_no_closer: assert property (@(posedge clk) disable iff (!rst_n)
            check_en |-> (dist_i[c] >= dist_i[sel_o]));
         // R3: every lower index is strictly farther, so ties go low
         a_r3_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            (check_en && (KW'(c) < sel_o)) |-> (dist_i[c] > dist_i[sel_o]));
      end
   endgenerate
endmodule

// File: rtl/lfr_resampler.sv
module lfr_resampler #(
   parameter int TRIG_W      = 12,
   parameter int DATA_W      = 12,
   parameter int POS_W       = 16,
   parameter int TAG_W       = 8,
   parameter int SUB         = 16,
   parameter bit TREE_SEARCH = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [TRIG_W-1:0]             in_trig_lo,
   input  logic [TRIG_W-1:0]             in_trig_hi,
   input  logic [DATA_W-1:0]             in_data_lo,
   input  logic [DATA_W-1:0]             in_data_hi,
   input  logic [POS_W-1:0]              in_pos,
   input  logic [TAG_W-1:0]              in_tag,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [POS_W+$clog2(SUB)-1:0]  out_pos,
   output logic [DATA_W-1:0]             out_data,
   output logic [TAG_W-1:0]              out_tag
);
   import lfr_pkg::*;

   localparam int KW = $clog2(SUB);

   // Elaboration-time parameter checks
   generate
      if (!lfr_is_pow2(SUB) || SUB < LFR_MIN_SUB) begin : g_bad_sub
         $error("lfr_resampler: SUB must be a power of two of at least 2");
      end
      if (TRIG_W < 2 || DATA_W < 2) begin : g_bad_width
         $error("lfr_resampler: sample widths must be at least 2");
      end
      if (POS_W < 1 || TAG_W < 1) begin : g_bad_side
         $error("lfr_resampler: position and tag widths must be at least 1");
      end
   endgenerate

   // Pipeline control: the whole pipe advances when the output slot frees up
   logic adv;
   logic v1, v2, v3;

   assign adv       = !out_valid || out_ready;
   assign in_ready  = adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         v2        <= 1'b0;
         v3        <= 1'b0;
         out_valid <= 1'b0;
      end else if (adv) begin
         v1        <= in_valid;
         v2        <= v1;
         v3        <= v2;
         out_valid <= v3;
      end
   end

   // Stage 1: capture the bracket
   logic [TRIG_W-1:0] t_lo1, t_hi1;
   logic [DATA_W-1:0] d_lo1, d_hi1;
   logic [POS_W-1:0]  pos1;
   logic [TAG_W-1:0]  tag1;

   always_ff @(posedge clk) begin
      if (adv) begin
         t_lo1 <= in_trig_lo;
         t_hi1 <= in_trig_hi;
         d_lo1 <= in_data_lo;
         d_hi1 <= in_data_hi;
         pos1  <= in_pos;
         tag1  <= in_tag;
      end
   end

   // Stage 2: all trigger candidates and their magnitudes
   logic [SUB-1:0][TRIG_W-1:0] cand;
   logic [SUB-1:0][TRIG_W-1:0] mag;

   generate
      for (genvar k = 0; k < SUB; k++) begin : g_cand
         lfr_lerp #(.W(TRIG_W), .KW(KW)) u_trig_lerp (
            .a_i (t_lo1),
            .b_i (t_hi1),
            .k_i (KW'(k)),
            .y_o (cand[k])
         );
         // two's complement magnitude; the most negative value maps to 2**(W-1)
         assign mag[k] = cand[k][TRIG_W-1] ? (~cand[k] + 1'b1) : cand[k];
      end
   endgenerate

   logic [SUB-1:0][TRIG_W-1:0] mag2;
   logic [DATA_W-1:0]          d_lo2, d_hi2;
   logic [POS_W-1:0]           pos2;
   logic [TAG_W-1:0]           tag2;

   always_ff @(posedge clk) begin
      if (adv) begin
         mag2  <= mag;
         d_lo2 <= d_lo1;
         d_hi2 <= d_hi1;
         pos2  <= pos1;
         tag2  <= tag1;
      end
   end

   // Stage 3: nearest-to-zero search
   logic [KW-1:0] k_sel;

   lfr_argmin #(.SUB(SUB), .DIST_W(TRIG_W), .TREE_SEARCH(TREE_SEARCH)) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .check_en (v2),
      .dist_i   (mag2),
      .sel_o    (k_sel)
   );

   logic [KW-1:0]     k3;
   logic [DATA_W-1:0] d_lo3, d_hi3;
   logic [POS_W-1:0]  pos3;
   logic [TAG_W-1:0]  tag3;

   always_ff @(posedge clk) begin
      if (adv) begin
         k3    <= k_sel;
         d_lo3 <= d_lo2;
         d_hi3 <= d_hi2;
         pos3  <= pos2;
         tag3  <= tag2;
      end
   end

   // Stage 4: data channel read out at the chosen step
   logic [DATA_W-1:0] d_at_k;

   lfr_lerp #(.W(DATA_W), .KW(KW)) u_data_lerp (
      .a_i (d_lo3),
      .b_i (d_hi3),
      .k_i (k3),
      .y_o (d_at_k)
   );

   always_ff @(posedge clk) begin
      if (adv) begin
         out_data <= d_at_k;
         out_pos  <= {pos3, k3};
         out_tag  <= tag3;
      end
   end

   // Bounds of the data pair, used only by the range check below
   logic [DATA_W-1:0] d_min3, d_max3;
   always_comb begin
      if ($signed(d_lo3) <= $signed(d_hi3)) begin
         d_min3 = d_lo3;
         d_max3 = d_hi3;
      end else begin
         d_min3 = d_hi3;
         d_max3 = d_lo3;
      end
   end

   // R4: the read-out value stays within the span of its two endpoints
   a_r4_in_span: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && v3) |=> (($signed(out_data) >= $signed($past(d_min3))) &&
                       ($signed(out_data) <= $signed($past(d_max3)))));

   // R9: a stalled result holds still
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pos) &&
                                     $stable(out_data) && $stable(out_tag)));

   // R6: a result only appears when one was in the last stage
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(v3));
endmodule

// File: tb/test_lfr_resampler.sv
module test_lfr_resampler;
   localparam int TW    = 6;
   localparam int DW    = 8;
   localparam int PW    = 6;
   localparam int GW    = 12;
   localparam int SUB   = 16;
   localparam int KW    = 4;
   localparam int TOTAL = 4096 + 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [TW-1:0] in_trig_lo = '0, in_trig_hi = '0;
   logic [DW-1:0] in_data_lo = '0, in_data_hi = '0;
   logic [PW-1:0] in_pos = '0;
   logic [GW-1:0] in_tag = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [PW+KW-1:0] out_pos;
   logic [DW-1:0] out_data;
   logic [GW-1:0] out_tag;

   lfr_resampler #(.TRIG_W(TW), .DATA_W(DW), .POS_W(PW), .TAG_W(GW),
                   .SUB(SUB), .TREE_SEARCH(1'b1)) i_lfr_resampler (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_trig_lo(in_trig_lo), .in_trig_hi(in_trig_hi),
      .in_data_lo(in_data_lo), .in_data_hi(in_data_hi),
      .in_pos(in_pos), .in_tag(in_tag),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_pos(out_pos), .out_data(out_data), .out_tag(out_tag)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int stall_cnt = 0;
   int exp_idx = 0;
   int first_out_cyc = -1;
   bit bp_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (bp_en) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = (lfsr[1:0] != 2'b00);
      end else begin
         out_ready = 1'b1;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic void stim(input int idx,
                                output logic [TW-1:0] a, output logic [TW-1:0] b,
                                output logic [DW-1:0] c, output logic [DW-1:0] e,
                                output logic [PW-1:0] p, output logic [GW-1:0] g);
      int m;
      m = idx % 4096;
      a = TW'(m >> 6);
      b = TW'(m);
      c = DW'(idx * 37 + 5);
      e = DW'(idx * 101 + 200);
      if (m % 64 == 0) begin
         c = 8'h80; e = 8'h7F;
      end else if (m % 64 == 1) begin
         c = 8'h7F; e = 8'h80;
      end
      p = PW'(idx * 7);
      g = GW'(idx);
   endfunction

   function automatic int line_at(input int lo, input int hi, input int k);
      real r;
      r = lo + ((hi - lo) * k) / 16.0 + 0.5;
      return $rtoi($floor(r));
   endfunction

   task automatic push(input int idx);
      stim(idx, in_trig_lo, in_trig_hi, in_data_lo, in_data_hi, in_pos, in_tag);
      in_valid = 1'b1;
      while (!in_ready) begin
         stall_cnt++;
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
      in_valid = 1'b0;
   endtask

   // Output monitor
   logic          hold_pend = 1'b0;
   logic [PW+KW-1:0] hold_pos;
   logic [DW-1:0] hold_data;
   logic [GW-1:0] hold_tag;

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (hold_pend) begin
            checks++;
            if (!(out_valid && out_pos == hold_pos && out_data == hold_data && out_tag == hold_tag)) begin
               fails++;
               $display("FAIL R9 hold: got v=%0b pos=%h data=%h tag=%h, expected v=1 pos=%h data=%h tag=%h",
                        out_valid, out_pos, out_data, out_tag, hold_pos, hold_data, hold_tag);
            end
         end
         hold_pend = out_valid && !out_ready;
         hold_pos  = out_pos;
         hold_data = out_data;
         hold_tag  = out_tag;

         if (out_valid && out_ready) begin
            logic [TW-1:0] a, b;
            logic [DW-1:0] c, e;
            logic [PW-1:0] p;
            logic [GW-1:0] g;
            int ai, bi, ci, ei, best_k, best_m, dexp;
            logic [PW+KW-1:0] pexp;
            if (first_out_cyc < 0) first_out_cyc = cyc;
            stim(exp_idx, a, b, c, e, p, g);
            ai = int'($signed(a)); bi = int'($signed(b));
            ci = int'($signed(c)); ei = int'($signed(e));
            best_k = 0;
            best_m = 1 << 30;
            for (int k = 0; k < SUB; k++) begin
               int v, mg;
               v  = line_at(ai, bi, k);
               mg = (v < 0) ? -v : v;
               if (mg < best_m) begin best_m = mg; best_k = k; end
            end
            dexp = line_at(ci, ei, best_k);
            pexp = {p, KW'(best_k)};

            checks++;
            if (out_pos != pexp) begin
               fails++;
               $display("FAIL R2/R3/R5 position idx %0d (a=%0d b=%0d): got %h expected %h",
                        exp_idx, ai, bi, out_pos, pexp);
            end
            checks++;
            if (int'($signed(out_data)) != dexp) begin
               fails++;
               $display("FAIL R4 data idx %0d (c=%0d e=%0d k=%0d): got %0d expected %0d",
                        exp_idx, ci, ei, best_k, $signed(out_data), dexp);
            end
            checks++;
            if (out_tag != g) begin
               fails++;
               $display("FAIL R6 tag order: got %h expected %h", out_tag, g);
            end
            exp_idx++;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 100000) begin
         fails++;
         $display("FAIL R6 watchdog: %0d of %0d results received, expected all", exp_idx, TOTAL);
         summary();
         $finish;
      end
   end

   initial begin
      int acc_cyc;
      repeat (3) @(negedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 in reset: out_valid=%b in_ready=%b, expected 0 and 1", out_valid, in_ready);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 after reset: out_valid=%b in_ready=%b, expected 0 and 1", out_valid, in_ready);
      end

      // R8: single bracket latency
      push(0);
      acc_cyc = cyc;
      repeat (8) begin @(negedge clk); #1; end
      checks++;
      if (first_out_cyc - acc_cyc != 3) begin
         fails++;
         $display("FAIL R8 latency: result %0d edges after accept edge, expected 3 (4th edge)",
                  first_out_cyc - acc_cyc);
      end

      // R7: back-to-back burst with the output always ready
      stall_cnt = 0;
      for (int i = 1; i < 41; i++) push(i);
      checks++;
      if (stall_cnt != 0) begin
         fails++;
         $display("FAIL R7 throughput: in_ready low %0d times, expected 0", stall_cnt);
      end

      // Exhaustive trigger sweep under random backpressure
      bp_en = 1'b1;
      for (int i = 41; i < TOTAL; i++) begin
         push(i);
         if (i % 7 == 0) begin @(negedge clk); #1; end
      end
      bp_en = 1'b0;
      while (exp_idx < TOTAL) begin @(negedge clk); #1; end
      repeat (6) begin @(negedge clk); #1; end

      checks++;
      if (exp_idx != TOTAL || out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R6 count: got %0d results (out_valid=%b), expected %0d and idle",
                  exp_idx, out_valid, TOTAL);
      end
      summary();
      $finish;
   end
endmodule